// File: doc/BRIEF.md
# Stacked-Capacitor Buffer Switch Sequencer

This block is a synchronous controller for an energy buffer built from one backbone capacitor and two supporting capacitors stacked on top of it. It takes digitized voltage codes for the DC bus and for each capacitor. It drives four gate signals: one for each of three supporting-block switch positions, where the middle position is a back-to-back pair with two gates.

After an enable, the block charges the capacitors to their starting voltages in three precharge phases. It then enters normal operation. In normal operation it steps along a three-rung ladder of switch positions. It moves one rung up each time the bus reaches an upper threshold and one rung down each time the bus falls to a lower threshold. The stacked voltages then cancel, and the bus stays inside a narrow window, nominally 21 V with 2 V peak to peak.

Every change of switch configuration is break-before-make, with a programmable dead time. Every threshold event must persist for a programmable number of consecutive samples before it acts. At the ends of the ladder the block holds its position and raises a full or an empty flag.

Top module: `stackBufferSeq`

## Requirements
- R1: A synchronous reset puts the block in idle, with all four gates low and both flags low. It stays there while enable is low.
- R2: On enable, the first precharge phase drives step0 and both step1 gates. It keeps this configuration until aux1Code and aux2Code are both at or above seedLevel. One capacitor alone at the level does not advance the phase.
- R3: The second precharge phase drives step0 only, until aux2Code is at or above aux2Target.
- R4: The third precharge phase drives step2 only, until backCode is at or above backTarget. Normal operation then starts on the lowest rung, with step0 on.
- R5: In normal operation, a qualified busCode >= busHighThr moves one rung up. The rungs in order are step0, then step1, then step2. A code of busHighThr-1 does not step.
- R6: A qualified busCode <= busLowThr moves one rung down, in exact reverse order. A code of busLowThr+1 does not step.
- R7: On the step2 rung, a qualified high event holds the position and sets fullFlag. A step down clears fullFlag.
- R8: On the step0 rung, a qualified low event holds the position and sets emptyFlag. A step up clears emptyFlag.
- R9: Every configuration change first holds all gates low for max(deadCycles,1) cycles. The new configuration then appears in the following cycle.
- R10: An event acts on the max(qualCount,1)-th consecutive clock edge on which its condition holds. A sample that fails the condition restarts the count. The count also restarts after each configuration change and its dead time.
- R11: The two step1 gates are always equal. In normal operation at most one rung is on.
- R12: Deasserting enable returns the block to idle. All gates and flags are low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Starts precharge when high; forces idle when low |
| busCode | input | 12 | DC bus voltage code |
| backCode | input | 12 | Backbone capacitor voltage code |
| aux1Code | input | 12 | Lower-voltage supporting capacitor code |
| aux2Code | input | 12 | Higher-voltage supporting capacitor code |
| busHighThr | input | 12 | Upper bus threshold (step up) |
| busLowThr | input | 12 | Lower bus threshold (step down) |
| seedLevel | input | 12 | Target for both supporting capacitors in phase one |
| aux2Target | input | 12 | Target for aux2 in phase two |
| backTarget | input | 12 | Target for the backbone capacitor in phase three |
| deadCycles | input | 8 | Dead time in cycles (0 acts as 1) |
| qualCount | input | 4 | Consecutive samples needed (0 acts as 1) |
| gateStep0 | output | 1 | Gate of the lowest rung switch |
| gateStep1Fwd | output | 1 | First gate of the middle rung pair |
| gateStep1Rev | output | 1 | Second gate of the middle rung pair |
| gateStep2 | output | 1 | Gate of the top rung switch |
| fullFlag | output | 1 | Top rung reached and a high event held |
| emptyFlag | output | 1 | Bottom rung reached and a low event held |

## Verification
On every cycle, the embedded properties check the following: the two middle gates stay equal, no gate rises unless all gates were low the cycle before, the rung moves by at most one step, each flag appears only on its own end rung, and dropping enable blanks the gates. Only the bench scenarios can show the rest: the exact order of the precharge phases and the ladder, the cycle on which an event acts after qualification, the restart of the count after a glitch, and the boundary codes either side of each threshold. The bench runs these scenarios across a grid of dead times and qualification counts.

// File: rtl/stackSeqPkg.sv
package stackSeqPkg;

  typedef enum logic [2:0] {PH_IDLE, PH_PRE_A, PH_PRE_B, PH_PRE_C, PH_RUN} phase_t;
  typedef enum logic [2:0] {CFG_OFF, CFG_SEED, CFG_ST0, CFG_ST1, CFG_ST2} cfg_t;

  // condition indices into the qualified vector
  localparam int C_HIGH   = 0;
  localparam int C_LOW    = 1;
  localparam int C_SEED   = 2;
  localparam int C_AUX2   = 3;
  localparam int C_BACK   = 4;
  localparam int NUM_COND = 5;

  localparam logic [1:0] LVL_TOP = 2'd2;

  typedef struct packed {
    logic clrQual;
  } ctlStrobe_t;

  function automatic cfg_t lvlCfg(input logic [1:0] lvl);
    case (lvl)
      2'd0:    return CFG_ST0;
      2'd1:    return CFG_ST1;
      default: return CFG_ST2;
    endcase
  endfunction

endpackage

// File: rtl/seqDatapath.sv
module seqDatapath
  import stackSeqPkg::*;
#(
  parameter int CODE_W = 12,
  parameter int QUAL_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CODE_W-1:0]   busCode,
  input  logic [CODE_W-1:0]   backCode,
  input  logic [CODE_W-1:0]   aux1Code,
  input  logic [CODE_W-1:0]   aux2Code,
  input  logic [CODE_W-1:0]   busHighThr,
  input  logic [CODE_W-1:0]   busLowThr,
  input  logic [CODE_W-1:0]   seedLevel,
  input  logic [CODE_W-1:0]   aux2Target,
  input  logic [CODE_W-1:0]   backTarget,
  input  logic [QUAL_W-1:0]   qualCount,
  input  ctlStrobe_t          strobe,
  output logic [NUM_COND-1:0] qual
);

  logic [NUM_COND-1:0] raw;
  logic [QUAL_W-1:0]   qualNeed;

  always_comb begin
    raw[C_HIGH] = busCode >= busHighThr;
    raw[C_LOW]  = busCode <= busLowThr;
    raw[C_SEED] = (aux1Code >= seedLevel) && (aux2Code >= seedLevel);
    raw[C_AUX2] = aux2Code >= aux2Target;
    raw[C_BACK] = backCode >= backTarget;
  end

  assign qualNeed = (qualCount == '0) ? QUAL_W'(1) : qualCount;

  for (genvar g = 0; g < NUM_COND; g++) begin : gCnt
    logic [QUAL_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst || strobe.clrQual || !raw[g]) cnt <= '0;
      else if (cnt != '1)                   cnt <= cnt + 1'b1;
    end

    assign qual[g] = raw[g] && (cnt >= qualNeed - QUAL_W'(1));

    // R10: a clear strobe restarts the consecutive-sample count
    p_clr_restart_r10: assert property (@(posedge clk) disable iff (rst)
      strobe.clrQual |=> (cnt == '0));
  end

endmodule

// File: rtl/seqControl.sv
module seqControl
  import stackSeqPkg::*;
#(
  parameter int DEAD_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [NUM_COND-1:0] qual,
  input  logic [DEAD_W-1:0]   deadCycles,
  output logic                gateStep0,
  output logic                gateStep1Fwd,
  output logic                gateStep1Rev,
  output logic                gateStep2,
  output logic                fullFlag,
  output logic                emptyFlag,
  output ctlStrobe_t          strobe
);

  phase_t            phase, nPhase;
  cfg_t              cfg, nCfg;
  logic [1:0]        lvl, nLvl;
  logic [DEAD_W-1:0] deadCnt, deadEff;
  logic              change, gatesOn;

  assign deadEff = (deadCycles == '0) ? DEAD_W'(1) : deadCycles;

  always_comb begin
    change = 1'b0;
    nPhase = phase;
    nCfg   = cfg;
    nLvl   = lvl;
    if (deadCnt == '0) begin
      case (phase)
        PH_IDLE: begin
          change = 1'b1; nPhase = PH_PRE_A; nCfg = CFG_SEED;
        end
        PH_PRE_A: if (qual[C_SEED]) begin
          change = 1'b1; nPhase = PH_PRE_B; nCfg = CFG_ST0;
        end
        PH_PRE_B: if (qual[C_AUX2]) begin
          change = 1'b1; nPhase = PH_PRE_C; nCfg = CFG_ST2;
        end
        PH_PRE_C: if (qual[C_BACK]) begin
          change = 1'b1; nPhase = PH_RUN; nCfg = CFG_ST0; nLvl = 2'd0;
        end
        PH_RUN: begin
          if (qual[C_HIGH]) begin
            if (lvl != LVL_TOP) begin
              change = 1'b1; nLvl = lvl + 2'd1; nCfg = lvlCfg(lvl + 2'd1);
            end
          end else if (qual[C_LOW] && lvl != 2'd0) begin
            change = 1'b1; nLvl = lvl - 2'd1; nCfg = lvlCfg(lvl - 2'd1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      phase     <= PH_IDLE;
      cfg       <= CFG_OFF;
      lvl       <= 2'd0;
      deadCnt   <= '0;
      fullFlag  <= 1'b0;
      emptyFlag <= 1'b0;
    end else if (deadCnt != '0) begin
      deadCnt <= deadCnt - 1'b1;
    end else if (change) begin
      phase     <= nPhase;
      cfg       <= nCfg;
      lvl       <= nLvl;
      deadCnt   <= deadEff;
      fullFlag  <= 1'b0;
      emptyFlag <= 1'b0;
    end else if (phase == PH_RUN) begin
      if (qual[C_HIGH])     fullFlag  <= 1'b1;
      else if (qual[C_LOW]) emptyFlag <= 1'b1;
    end
  end

  assign strobe.clrQual = !enable || (phase == PH_IDLE) || (deadCnt != '0) || change;

  assign gatesOn      = (deadCnt == '0);
  assign gateStep0    = gatesOn && (cfg == CFG_SEED || cfg == CFG_ST0);
  assign gateStep1Fwd = gatesOn && (cfg == CFG_SEED || cfg == CFG_ST1);
  assign gateStep1Rev = gatesOn && (cfg == CFG_SEED || cfg == CFG_ST1);
  assign gateStep2    = gatesOn && (cfg == CFG_ST2);

  // R11: the back-to-back pair never disagrees
  p_pair_equal_r11: assert property (@(posedge clk) disable iff (rst)
    gateStep1Fwd == gateStep1Rev);

  // R11: one rung at most in normal operation
  p_one_rung_r11: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN) |-> ($countones({gateStep0, gateStep1Fwd, gateStep2}) <= 1));

  // R9: any rising gate was preceded by a cycle with every gate low
  p_break_make_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(gateStep0) || $rose(gateStep1Fwd) || $rose(gateStep2)) |->
      $past({gateStep0, gateStep1Fwd, gateStep1Rev, gateStep2} == 4'b0000));

  // R5 / R6: the rung moves by at most one per cycle
  p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_RUN) && $past(phase == PH_RUN)) |->
      ((lvl == $past(lvl)) || (lvl == $past(lvl) + 2'd1) || ($past(lvl) == lvl + 2'd1)));

  // R7: full only while resting on the top rung
  p_full_top_r7: assert property (@(posedge clk) disable iff (rst)
    fullFlag |-> (gateStep2 && phase == PH_RUN));

  // R8: empty only while resting on the bottom rung
  p_empty_bottom_r8: assert property (@(posedge clk) disable iff (rst)
    emptyFlag |-> (gateStep0 && phase == PH_RUN));

  // R12: dropping enable blanks every gate on the next cycle
  p_disable_off_r12: assert property (@(posedge clk) disable iff (rst)
    !enable |=> ({gateStep0, gateStep1Fwd, gateStep1Rev, gateStep2, fullFlag, emptyFlag} == 6'b0));

endmodule

// File: rtl/stackBufferSeq.sv
module stackBufferSeq
  import stackSeqPkg::*;
#(
  parameter int CODE_W = 12,
  parameter int DEAD_W = 8,
  parameter int QUAL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [CODE_W-1:0] busCode,
  input  logic [CODE_W-1:0] backCode,
  input  logic [CODE_W-1:0] aux1Code,
  input  logic [CODE_W-1:0] aux2Code,
  input  logic [CODE_W-1:0] busHighThr,
  input  logic [CODE_W-1:0] busLowThr,
  input  logic [CODE_W-1:0] seedLevel,
  input  logic [CODE_W-1:0] aux2Target,
  input  logic [CODE_W-1:0] backTarget,
  input  logic [DEAD_W-1:0] deadCycles,
  input  logic [QUAL_W-1:0] qualCount,
  output logic              gateStep0,
  output logic              gateStep1Fwd,
  output logic              gateStep1Rev,
  output logic              gateStep2,
  output logic              fullFlag,
  output logic              emptyFlag
);

  logic [NUM_COND-1:0] qual;
  ctlStrobe_t          strobe;

  seqDatapath #(.CODE_W(CODE_W), .QUAL_W(QUAL_W)) i_datapath (
    .clk(clk), .rst(rst),
    .busCode(busCode), .backCode(backCode), .aux1Code(aux1Code), .aux2Code(aux2Code),
    .busHighThr(busHighThr), .busLowThr(busLowThr),
    .seedLevel(seedLevel), .aux2Target(aux2Target), .backTarget(backTarget),
    .qualCount(qualCount), .strobe(strobe), .qual(qual)
  );

  seqControl #(.DEAD_W(DEAD_W)) i_control (
    .clk(clk), .rst(rst), .enable(enable), .qual(qual), .deadCycles(deadCycles),
    .gateStep0(gateStep0), .gateStep1Fwd(gateStep1Fwd), .gateStep1Rev(gateStep1Rev),
    .gateStep2(gateStep2), .fullFlag(fullFlag), .emptyFlag(emptyFlag), .strobe(strobe)
  );

endmodule

// File: tb/test_stackBufferSeq.sv
module test_stackBufferSeq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [11:0] busCode = 12'd2100, backCode = '0, aux1Code = '0, aux2Code = '0;
  logic [11:0] busHighThr = 12'd2200, busLowThr = 12'd2000;
  logic [11:0] seedLevel = 12'd100, aux2Target = 12'd200, backTarget = 12'd1800;
  logic [7:0]  deadCycles = '0;
  logic [3:0]  qualCount = '0;
  logic gateStep0, gateStep1Fwd, gateStep1Rev, gateStep2, fullFlag, emptyFlag;

  // observed word: {step0, step1Fwd, step1Rev, step2, full, empty}
  localparam logic [5:0] W_OFF  = 6'b000000;
  localparam logic [5:0] W_SEED = 6'b111000;
  localparam logic [5:0] W_ST0  = 6'b100000;
  localparam logic [5:0] W_ST1  = 6'b011000;
  localparam logic [5:0] W_ST2  = 6'b000100;
  localparam logic [5:0] F_FULL = 6'b000010;
  localparam logic [5:0] F_EMPT = 6'b000001;

  int nChk = 0, nFail = 0;
  int dEff = 1, nEff = 1;

  always #4 clk = ~clk;

  stackBufferSeq i_stackBufferSeq (
    .clk(clk), .rst(rst), .enable(enable),
    .busCode(busCode), .backCode(backCode), .aux1Code(aux1Code), .aux2Code(aux2Code),
    .busHighThr(busHighThr), .busLowThr(busLowThr),
    .seedLevel(seedLevel), .aux2Target(aux2Target), .backTarget(backTarget),
    .deadCycles(deadCycles), .qualCount(qualCount),
    .gateStep0(gateStep0), .gateStep1Fwd(gateStep1Fwd), .gateStep1Rev(gateStep1Rev),
    .gateStep2(gateStep2), .fullFlag(fullFlag), .emptyFlag(emptyFlag)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] expv);
    logic [5:0] act;
    act = {gateStep0, gateStep1Fwd, gateStep1Rev, gateStep2, fullFlag, emptyFlag};
    nChk++;
    if (act !== expv) begin
      nFail++;
      $display("FAIL %s actual=%b expected=%b (dead=%0d qual=%0d)",
               req, act, expv, deadCycles, qualCount);
    end
  endtask

  // R9: gates low for dEff cycles after the changing edge, then the new word
  task automatic settle(input string req, input logic [5:0] w);
    for (int i = 0; i < dEff; i++) begin
      chk({req, "/R9"}, W_OFF);
      tick();
    end
    chk(req, w);
  endtask

  // R10: nEff-1 qualifying edges leave the word unchanged; the nEff-th acts
  task automatic qualWait(input string req, input logic [5:0] cur);
    for (int i = 0; i < nEff - 1; i++) begin
      tick();
      chk({req, "/R10"}, cur);
    end
    tick();
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    automatic int deadSet[4] = '{0, 1, 3, 6};
    automatic int qualSet[4] = '{0, 1, 2, 5};
    @(negedge clk);
    foreach (deadSet[di]) begin
      foreach (qualSet[qi]) begin
        deadCycles = 8'(deadSet[di]);
        qualCount  = 4'(qualSet[qi]);
        dEff = (deadSet[di] == 0) ? 1 : deadSet[di];
        nEff = (qualSet[qi] == 0) ? 1 : qualSet[qi];
        busCode = 12'd2100; aux1Code = '0; aux2Code = '0; backCode = '0;

        // R1: reset state, enable held high during reset is ignored
        rst = 1'b1; enable = 1'b1;
        tick(); tick();
        chk("R1", W_OFF);
        rst = 1'b0; enable = 1'b0;
        for (int i = 0; i < 3; i++) begin tick(); chk("R1", W_OFF); end

        // R2: seed phase needs both supporting codes
        enable = 1'b1;
        tick();
        settle("R2", W_SEED);
        aux1Code = 12'd100;
        for (int i = 0; i < nEff + 2; i++) begin tick(); chk("R2", W_SEED); end
        aux2Code = 12'd99;
        tick(); chk("R2", W_SEED);
        if (nEff > 1) begin
          aux2Code = 12'd100;
          tick(); chk("R10", W_SEED);
          aux2Code = 12'd99;               // glitch restarts count
          tick(); chk("R10", W_SEED);
        end
        aux2Code = 12'd100;
        qualWait("R2", W_SEED);
        settle("R3", W_ST0);

        // R3: second phase until aux2 reaches its target
        aux2Code = 12'd199;
        for (int i = 0; i < nEff + 1; i++) begin tick(); chk("R3", W_ST0); end
        aux2Code = 12'd200;
        qualWait("R3", W_ST0);
        settle("R4", W_ST2);

        // R4: third phase until backbone reaches its target
        backCode = 12'd1799;
        for (int i = 0; i < nEff + 1; i++) begin tick(); chk("R4", W_ST2); end
        backCode = 12'd1800;
        qualWait("R4", W_ST2);
        settle("R4", W_ST0);

        // R5: boundary below upper threshold does not step
        busCode = 12'd2199;
        for (int i = 0; i < nEff + 2; i++) begin tick(); chk("R5", W_ST0); end
        busCode = 12'd2200;
        qualWait("R5", W_ST0);
        settle("R5", W_ST1);
        busCode = 12'd2300;
        qualWait("R5", W_ST1);
        settle("R5", W_ST2);

        // R7: top rung holds and sets full
        qualWait("R7", W_ST2);
        chk("R7", W_ST2 | F_FULL);
        for (int i = 0; i < 3; i++) begin tick(); chk("R7", W_ST2 | F_FULL); end

        // R6: boundary above lower threshold does not step
        busCode = 12'd2001;
        for (int i = 0; i < nEff + 2; i++) begin tick(); chk("R6", W_ST2 | F_FULL); end
        busCode = 12'd2000;
        qualWait("R6", W_ST2 | F_FULL);
        settle("R6", W_ST1);            // full cleared by the step (R7)
        busCode = 12'd1500;
        qualWait("R6", W_ST1);
        settle("R6", W_ST0);

        // R8: bottom rung holds and sets empty
        qualWait("R8", W_ST0);
        chk("R8", W_ST0 | F_EMPT);
        busCode = 12'd2100;
        for (int i = 0; i < 3; i++) begin tick(); chk("R8", W_ST0 | F_EMPT); end
        busCode = 12'd2250;
        qualWait("R8", W_ST0 | F_EMPT);
        settle("R8", W_ST1);

        // R12: enable low returns to idle at once
        enable = 1'b0;
        tick(); chk("R12", W_OFF);
        tick(); chk("R12", W_OFF);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule